// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It supports six instructions: register add and subtract without overflow traps, OR with a zero-extended immediate, word load, word store, and branch when two registers are equal. A decoder turns each opcode into one fixed set of datapath selects. These selects choose the write-back register, the immediate extension mode, the second ALU operand, the ALU operation, the data-memory write, the write-back source and the next-PC source. The branch decision comes from the zero flag of an ALU subtraction.

Instruction memory and data memory are small internal word arrays. A debug port lets the environment fill either array while the core is held in reset. The same port reads back any memory word or any register combinationally, so program results can be checked from outside the core.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and every register becomes 0. No instruction writes a register or data memory during reset.
- R2: Instruction fields decode as opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0] and immediate [15:0]. Opcodes: 0x00 register type (function 0x21 add, 0x23 subtract), 0x0D OR-immediate, 0x23 load, 0x2B store, 0x04 branch-equal.
- R3: Add and subtract write rs+rt and rs−rt modulo 2^32 into register rd. Carries and borrows are dropped.
- R4: OR-immediate writes rs OR the zero-extended immediate into register rt.
- R5: Load writes into rt the data-memory word selected by address bits [DMEM_AW+1:2] of rs plus the sign-extended immediate.
- R6: Store writes rt into the data-memory word at rs plus the sign-extended immediate. No other instruction changes data memory.
- R7: Branch-equal sets the next PC to PC+4+(sign-extended immediate × 4) when rs equals rt. Otherwise, and for every non-branch instruction, the next PC is PC+4.
- R8: Register 0 always reads 0, and writes to it are discarded.
- R9: Any other opcode executes as a no-op that only advances the PC by 4. A register-type word whose function is not 0x21 or 0x23, or whose shift amount is nonzero, also executes as that no-op.
- R10: When `dbg_we` is high at a rising edge, `dbg_wdata` is written to the word `dbg_addr` of data memory (`dbg_tgt`=1) or instruction memory (`dbg_tgt`=0). `dbg_rdata` shows that word combinationally, and `dbg_reg_data` shows register `dbg_reg_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_we | input | 1 | Debug memory write enable |
| dbg_tgt | input | 1 | Debug target: 0 instruction memory, 1 data memory |
| dbg_addr | input | DBG_AW | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Word at dbg_addr in the selected memory |
| dbg_reg_idx | input | 5 | Register to observe |
| dbg_reg_data | output | 32 | Value of register dbg_reg_idx |
| pc_o | output | 32 | Current program counter |

## Verification
Each architectural state element is visible at the ports. A wrong control select or ALU operation shows up as a wrong register or memory word, which can be read through the debug port as soon as the faulty instruction retires, one clock later. A wrong next-PC choice shows up on `pc_o` on the following edge. Its effects then persist: skipped or repeated instructions leave registers that should have stayed zero changed, or registers that should have changed still zero. The program is built so that every select takes both of its values at least once, and so that each result ends in a register or memory word that no other instruction rewrites.

// File: rtl/sc_pkg.sv
// Shared encodings and the control word for the single-cycle core.
// Assumes a 32-bit instruction word with fixed field positions.
package sc_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU   = 6'h21;
    localparam logic [5:0] FN_SUBU   = 6'h23;

    // One select per datapath decision point.
    typedef struct packed {
        logic    dst_rd;     // 1: write rd, 0: write rt
        logic    reg_we;     // register file write
        logic    ext_signed; // 1: sign extend, 0: zero extend
        logic    opb_imm;    // 1: ALU B is immediate, 0: second read bus
        alu_op_e alu_op;     // ALU operation
        logic    mem_we;     // data memory write
        logic    wb_mem;     // 1: write back memory data, 0: ALU result
        logic    br_sel;     // 1: branch candidate, 0: PC+4
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl_decode.sv
// Main control decoder: maps opcode, function and shift fields to the
// control word. Unknown encodings yield an all-inactive word (no-op).
module sc_ctrl_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output ctrl_t      ctl
);

    // Fixed control setting per recognised instruction.
    always_comb begin
        ctl = '{dst_rd: 1'b0, reg_we: 1'b0, ext_signed: 1'b0, opb_imm: 1'b0,
                alu_op: ALU_ADD, mem_we: 1'b0, wb_mem: 1'b0, br_sel: 1'b0};
        unique case (opcode)
            OPC_RTYPE: begin
                if (shamt == 5'd0 && funct == FN_ADDU) begin
                    ctl.dst_rd = 1'b1;
                    ctl.reg_we = 1'b1;
                    ctl.alu_op = ALU_ADD;
                end else if (shamt == 5'd0 && funct == FN_SUBU) begin
                    ctl.dst_rd = 1'b1;
                    ctl.reg_we = 1'b1;
                    ctl.alu_op = ALU_SUB;
                end
            end
            OPC_ORI: begin
                ctl.reg_we  = 1'b1;
                ctl.opb_imm = 1'b1;
                ctl.alu_op  = ALU_OR;
            end
            OPC_LW: begin
                ctl.reg_we     = 1'b1;
                ctl.ext_signed = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.wb_mem     = 1'b1;
            end
            OPC_SW: begin
                ctl.ext_signed = 1'b1;
                ctl.opb_imm    = 1'b1;
                ctl.mem_we     = 1'b1;
            end
            OPC_BEQ: begin
                ctl.ext_signed = 1'b1;
                ctl.alu_op     = ALU_SUB;
                ctl.br_sel     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
// Three-operation ALU (add, subtract, OR) with an all-zero result flag.
// Results wrap modulo 2^W; no overflow indication.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
// Register file with two combinational read ports, one write port and a
// third read port for debug observation. Entry 0 is hard-wired to zero.
// Synchronous active-low reset clears every entry.
module sc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra,
    input  logic [AW-1:0] rb,
    input  logic [AW-1:0] rc,
    output logic [W-1:0]  da,
    output logic [W-1:0]  db,
    output logic [W-1:0]  dc,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    localparam int NREG = 2 ** AW;

    logic [W-1:0] regs [NREG];

    // Write port: clear on reset, skip entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with entry 0 forced to zero.
    always_comb begin
        da = (ra == '0) ? '0 : regs[ra];
        db = (rb == '0) ? '0 : regs[rb];
        dc = (rc == '0) ? '0 : regs[rc];
    end

    // A write to a nonzero entry is visible on the next cycle.
    assert_reg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
// Single-cycle core: PC, instruction memory, decoder, register file,
// immediate extender, ALU, data memory and next-PC selection.
// Assumes 32-bit instructions; memories are word arrays indexed by address
// bits above the byte offset. Debug writes take priority over stores.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    parameter int DBG_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_we,
    input  logic              dbg_tgt,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic [31:0]       dbg_wdata,
    output logic [31:0]       dbg_rdata,
    input  logic [4:0]        dbg_reg_idx,
    output logic [31:0]       dbg_reg_data,
    output logic [31:0]       pc_o
);

    localparam int XLEN     = 32;
    localparam int RAW      = 5;
    localparam int IMEM_WDS = 2 ** IMEM_AW;
    localparam int DMEM_WDS = 2 ** DMEM_AW;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] imem [IMEM_WDS];
    logic [XLEN-1:0] dmem [DMEM_WDS];

    ctrl_t           ctl;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, w_dst;
    logic [15:0]     f_imm;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, opb, alu_y, mem_rd, wb_data, br_off;
    logic            alu_zero;
    logic            take_br;
    logic [DMEM_AW-1:0] d_idx;

    // Instruction fetch and field split.
    assign instr = imem[pc_q[IMEM_AW+1:2]];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_imm = instr[15:0];

    sc_ctrl_decode i_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .shamt  (instr[10:6]),
        .ctl    (ctl)
    );

    assign w_dst = ctl.dst_rd ? f_rd : f_rt;

    sc_regfile #(.W(XLEN), .AW(RAW)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (f_rs),
        .rb    (f_rt),
        .rc    (dbg_reg_idx),
        .da    (rs_val),
        .db    (rt_val),
        .dc    (dbg_reg_data),
        .we    (ctl.reg_we),
        .waddr (w_dst),
        .wdata (wb_data)
    );

    // Immediate extender and ALU operand B select.
    always_comb begin
        imm_ext = ctl.ext_signed ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                 : {{(XLEN-16){1'b0}}, f_imm};
        opb     = ctl.opb_imm ? imm_ext : rt_val;
    end

    sc_alu #(.W(XLEN)) i_alu (
        .a    (rs_val),
        .b    (opb),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory read and write-back select.
    assign d_idx   = alu_y[DMEM_AW+1:2];
    assign mem_rd  = dmem[d_idx];
    assign wb_data = ctl.wb_mem ? mem_rd : alu_y;

    // Memory writes: debug port first, then stores outside reset.
    always_ff @(posedge clk) begin
        if (dbg_we && !dbg_tgt) begin
            imem[dbg_addr[IMEM_AW-1:0]] <= dbg_wdata;
        end
        if (dbg_we && dbg_tgt) begin
            dmem[dbg_addr[DMEM_AW-1:0]] <= dbg_wdata;
        end else if (rst_n && ctl.mem_we) begin
            dmem[d_idx] <= rt_val;
        end
    end

    // Next-PC selection from branch select and zero flag.
    always_comb begin
        pc_plus4 = pc_q + 32'd4;
        br_off   = {imm_ext[XLEN-3:0], 2'b00};
        take_br  = ctl.br_sel & alu_zero;
        pc_next  = take_br ? (pc_plus4 + br_off) : pc_plus4;
    end

    // PC register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign dbg_rdata = dbg_tgt ? dmem[dbg_addr[DMEM_AW-1:0]]
                               : imem[dbg_addr[IMEM_AW-1:0]];

    // Non-branch opcodes always step by one word.
    assert_pc_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] != OPC_BEQ) |=> pc_q == $past(pc_q) + 32'd4);

    // Equal operands on a branch land on the offset target.
    assert_branch_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OPC_BEQ && rs_val == rt_val) |=>
        pc_q == $past(pc_q) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

    // A store lands rt in the addressed data word.
    assert_store_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mem_we && !(dbg_we && dbg_tgt)) |=> dmem[$past(d_idx)] == $past(rt_val));

    // Register 0 observed through the debug port stays zero.
    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_reg_idx == 5'd0) |-> dbg_reg_data == 32'd0);

endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
    import sc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_we = 1'b0;
    logic        dbg_tgt = 1'b0;
    logic [5:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [4:0]  dbg_reg_idx = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] pc_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sc_core i_sc_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_we       (dbg_we),
        .dbg_tgt      (dbg_tgt),
        .dbg_addr     (dbg_addr),
        .dbg_wdata    (dbg_wdata),
        .dbg_rdata    (dbg_rdata),
        .dbg_reg_idx  (dbg_reg_idx),
        .dbg_reg_data (dbg_reg_data),
        .pc_o         (pc_o)
    );

    // Check kinds: 0 register, 1 data word, 2 PC, 3 instruction word.
    // Entry: {kind[1:0], idx[5:0], expected[31:0], requirement[5:0]}
    localparam logic [45:0] CHECKS [19] = '{
        {2'd0, 6'd1,  32'h0000_1234, 6'd4},  // R4 ori from r0
        {2'd0, 6'd2,  32'h0000_FFFF, 6'd4},  // R4 zero extension
        {2'd0, 6'd3,  32'h0001_1233, 6'd3},  // R3 add
        {2'd0, 6'd4,  32'hFFFF_1235, 6'd3},  // R3 subtract with borrow
        {2'd0, 6'd12, 32'hFFFE_246A, 6'd3},  // R3 add carry dropped
        {2'd0, 6'd5,  32'h0001_1233, 6'd5},  // R5 load positive offset
        {2'd0, 6'd7,  32'hFFFF_1235, 6'd5},  // R5 load negative offset
        {2'd1, 6'd2,  32'h0001_1233, 6'd6},  // R6 store word 2
        {2'd1, 6'd3,  32'hFFFF_1235, 6'd6},  // R6 store word 3
        {2'd1, 6'd0,  32'h0000_0000, 6'd6},  // R6 untouched word
        {2'd1, 6'd1,  32'h0000_0000, 6'd6},  // R6 untouched word
        {2'd0, 6'd0,  32'h0000_0000, 6'd8},  // R8 write to r0 dropped
        {2'd0, 6'd8,  32'h0000_1234, 6'd8},  // R8 r0 reads zero
        {2'd0, 6'd9,  32'h0000_0001, 6'd7},  // R7 not-taken falls through
        {2'd0, 6'd10, 32'h0000_0000, 6'd7},  // R7 taken branch skips
        {2'd0, 6'd13, 32'h0000_0000, 6'd9},  // R9 bad function is no-op
        {2'd0, 6'd11, 32'h0000_0007, 6'd9},  // R9 execution resumes
        {2'd2, 6'd0,  32'h0000_004C, 6'd7},  // R7 backward branch holds PC
        {2'd3, 6'd15, 32'hFC21_FFFF, 6'd10}  // R10 instruction readback
    };

    function automatic logic [31:0] rty(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {OPC_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] ity(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic poke(input logic tgt, input int addr, input logic [31:0] data);
        @(negedge clk);
        dbg_tgt = tgt; dbg_addr = 6'(addr); dbg_wdata = data; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] kind, input int idx, output logic [31:0] val);
        @(negedge clk);
        dbg_reg_idx = 5'(idx);
        dbg_addr = 6'(idx);
        dbg_tgt = (kind == 2'd1);
        #1;
        case (kind)
            2'd0:    val = dbg_reg_data;
            2'd2:    val = pc_o;
            default: val = dbg_rdata;
        endcase
    endtask

    initial begin
        logic [31:0] v;
        // R1: reset state with program word 0 present.
        for (int i = 0; i < 64; i++) begin
            poke(1'b0, i, 32'h0);
            poke(1'b1, i, 32'h0);
        end
        poke(1'b0, 0,  ity(OPC_ORI, 0, 1, 16'h1234));
        poke(1'b0, 1,  ity(OPC_ORI, 0, 2, 16'hFFFF));
        poke(1'b0, 2,  rty(1, 2, 3, FN_ADDU));
        poke(1'b0, 3,  rty(1, 2, 4, FN_SUBU));
        poke(1'b0, 4,  ity(OPC_SW, 0, 3, 16'h0008));
        poke(1'b0, 5,  ity(OPC_LW, 0, 5, 16'h0008));
        poke(1'b0, 6,  ity(OPC_ORI, 0, 6, 16'h0010));
        poke(1'b0, 7,  ity(OPC_SW, 6, 4, 16'hFFFC));
        poke(1'b0, 8,  ity(OPC_LW, 6, 7, 16'hFFFC));
        poke(1'b0, 9,  ity(OPC_ORI, 0, 0, 16'h0055));
        poke(1'b0, 10, rty(0, 1, 8, FN_ADDU));
        poke(1'b0, 11, ity(OPC_BEQ, 1, 2, 16'h0005));
        poke(1'b0, 12, ity(OPC_ORI, 0, 9, 16'h0001));
        poke(1'b0, 13, ity(OPC_BEQ, 3, 5, 16'h0001));
        poke(1'b0, 14, ity(OPC_ORI, 0, 10, 16'h0BAD));
        poke(1'b0, 15, 32'hFC21_FFFF);
        poke(1'b0, 16, rty(1, 1, 13, 6'h20));
        poke(1'b0, 17, rty(4, 4, 12, FN_ADDU));
        poke(1'b0, 18, ity(OPC_ORI, 0, 11, 16'h0007));
        poke(1'b0, 19, ity(OPC_BEQ, 0, 0, 16'hFFFF));

        peek(2'd2, 0, v); check("R1 pc in reset", v, 32'h0);
        peek(2'd0, 1, v); check("R1 no write in reset", v, 32'h0);

        @(negedge clk); rst_n = 1'b1;
        repeat (40) @(posedge clk);

        // Table walk over final architectural state.
        for (int k = 0; k < 19; k++) begin
            peek(CHECKS[k][45:44], int'(CHECKS[k][43:38]), v);
            check($sformatf("R%0d entry %0d", CHECKS[k][5:0], k), v, CHECKS[k][37:6]);
        end

        // R1: reset mid-run clears PC and registers.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        peek(2'd2, 0, v); check("R1 pc after reset", v, 32'h0);
        peek(2'd0, 3, v); check("R1 reg cleared", v, 32'h0);
        peek(2'd1, 2, v); check("R1 data kept", v, 32'h0001_1233);

        // R2 / R7: single steps after release.
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        check("R7 step one", pc_o, 32'h4);
        check("R2 ori field", dbg_reg_data, 32'h0);
        peek(2'd0, 1, v); check("R2 rt target", v, 32'h0000_1234);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule